// File: doc/BRIEF.md
# FIR Multiply-Accumulate Engine with Modulo Address Generation

This block computes a finite impulse response filter one input sample at a time. Samples arrive over a valid/ready handshake. Coefficients are written through a simple write port. Each accepted sample goes into a circular sample store of `TAPS` entries, where it overwrites the oldest entry. The engine then runs a fixed multiply-accumulate loop over the window.

Two address counters drive the loop. The coefficient address counts upward and the sample address counts downward, and both wrap modulo `TAPS`. The operand registers are the registered read ports of the two memories. They reload on every loop step, in the same cycle as the accumulation.

The accumulator carries `$clog2(TAPS)` guard bits above the product width. Only the final sum is clamped to the signed output width. The result appears as a single-cycle valid pulse.

Top module: `fir_mac_agu`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `y_valid` is 0, `s_ready` is 1 and `y_data` is 0.
- R2: A sample is taken on a rising edge where `s_valid` and `s_ready` are both 1. From the next cycle, `s_ready` stays 0 until the cycle in which that sample's result is presented.
- R3: Each accepted sample yields exactly one `y_valid` pulse, one cycle wide. The pulse is visible `TAPS+1` clock edges after the accepting edge. `y_data` keeps its value while `y_valid` is 0.
- R4: The result is the sum over i = 0..TAPS-1 of sample(newest - i) times coef[i]. Coefficient index 0 weights the sample just accepted, and all values are two's-complement signed.
- R5: Only the `TAPS` most recent samples contribute, because the store is a ring. The sample accepted `TAPS` samples before the newest has no effect, and this holds across any number of wraps of the ring.
- R6: A cycle with `coef_we`=1 stores `coef_data` as coef[`coef_addr`]. A write made while the engine is idle applies to the next sample.
- R7: A sum above 2^(OW-1)-1 yields 2^(OW-1)-1, and a sum below -2^(OW-1) yields -2^(OW-1).
- R8: Clamping is applied to the final sum only. A partial sum that leaves the output range and returns into it gives the exact result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(TAPS) | Coefficient index to write |
| coef_data | input | CW | Signed coefficient value |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Engine idle, sample can be taken |
| s_data | input | DW | Signed input sample |
| y_valid | output | 1 | One-cycle result strobe |
| y_data | output | OW | Signed, clamped filter output |

## Verification
The bench uses a 4-tap configuration and tries the filter with several kinds of input:
- A single impulse followed by zeros reads the coefficients back in order. This separates a forward coefficient walk from a reversed one, and exposes a window that keeps too many or too few taps.
- A step and a scrambled sweep through all 256 sample values wrap the ring many times. They catch a wrong modulo wrap on either address counter.
- Runs of full-scale operands drive the sum past both output limits.
- A pattern whose partial sum rises above the positive limit and falls back tells final-only clamping apart from clamping at every step.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } fir_state_e;
endpackage

// File: rtl/fir_ram.sv
// Simple dual-port memory with registered read (block RAM friendly).
module fir_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_agu.sv
// Two modulo-TAPS address registers: coefficient walks up, samples walk down.
module fir_agu #(
  parameter int TAPS = 8,
  localparam int IW  = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          step,
  input  logic [IW-1:0] base,
  output logic [IW-1:0] coef_addr,
  output logic [IW-1:0] samp_addr
);
  localparam logic [IW-1:0] LAST = IW'(TAPS - 1);

  function automatic logic [IW-1:0] mod_inc(input logic [IW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  function automatic logic [IW-1:0] mod_dec(input logic [IW-1:0] a);
    return (a == '0) ? LAST : a - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      coef_addr <= '0;
      samp_addr <= '0;
    end else if (start) begin
      coef_addr <= mod_inc('0);
      samp_addr <= mod_dec(base);
    end else if (step) begin
      coef_addr <= mod_inc(coef_addr);
      samp_addr <= mod_dec(samp_addr);
    end
  end
endmodule

// File: rtl/fir_mac.sv
// Accumulator with guard bits; clamps only the final sum.
module fir_mac #(
  parameter int TAPS = 8,
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int OW   = 16,
  localparam int PW  = DW + CW,
  localparam int AW  = PW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 last,
  input  logic signed [DW-1:0] mx,
  input  logic signed [CW-1:0] my,
  output logic                 y_valid,
  output logic [OW-1:0]        y_data
);
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] sum;
  logic [OW-1:0]        y_sat;

  assign prod = mx * my;
  assign sum  = acc + {{(AW-PW){prod[PW-1]}}, prod};

  generate
    if (AW > OW) begin : g_clamp
      localparam logic signed [AW-1:0] OMAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
      localparam logic signed [AW-1:0] OMIN = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};
      always_comb begin
        if (sum > OMAX)      y_sat = {1'b0, {(OW-1){1'b1}}};
        else if (sum < OMIN) y_sat = {1'b1, {(OW-1){1'b0}}};
        else                 y_sat = sum[OW-1:0];
      end
    end else begin : g_extend
      assign y_sat = OW'(sum);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      y_valid <= 1'b0;
      y_data  <= '0;
    end else begin
      y_valid <= 1'b0;
      if (clr) begin
        acc <= '0;
      end else if (en) begin
        acc <= sum;
        if (last) begin
          y_data  <= y_sat;
          y_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fir_mac_agu.sv
module fir_mac_agu #(
  parameter int TAPS = 8,
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int OW   = 16,
  localparam int IW  = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          coef_we,
  input  logic [IW-1:0] coef_addr,
  input  logic [CW-1:0] coef_data,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          y_valid,
  output logic [OW-1:0] y_data
);
  import fir_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(TAPS - 1);

  fir_state_e    state;
  logic [IW-1:0] wr_ptr;
  logic [IW-1:0] head;
  logic [IW-1:0] step_cnt;
  logic [IW-1:0] agu_coef;
  logic [IW-1:0] agu_samp;
  logic [IW-1:0] x_raddr;
  logic [IW-1:0] c_raddr;
  logic [DW-1:0] x_rd;
  logic [CW-1:0] c_rd;
  logic          take;
  logic          in_load;
  logic          in_run;
  logic          last_step;

  assign s_ready   = (state == ST_IDLE);
  assign take      = s_valid && s_ready;
  assign in_load   = (state == ST_LOAD);
  assign in_run    = (state == ST_RUN);
  assign last_step = in_run && (step_cnt == LAST);
  assign x_raddr   = in_load ? head : agu_samp;
  assign c_raddr   = in_load ? '0   : agu_coef;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wr_ptr   <= '0;
      head     <= '0;
      step_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (take) begin
          head   <= wr_ptr;
          wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          step_cnt <= '0;
          state    <= ST_RUN;
        end
        ST_RUN: begin
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  fir_ram #(.W(DW), .DEPTH(TAPS)) u_samples (
    .clk  (clk),
    .we   (take),
    .waddr(wr_ptr),
    .wdata(s_data),
    .raddr(x_raddr),
    .rdata(x_rd)
  );

  fir_ram #(.W(CW), .DEPTH(TAPS)) u_coefs (
    .clk  (clk),
    .we   (coef_we),
    .waddr(coef_addr),
    .wdata(coef_data),
    .raddr(c_raddr),
    .rdata(c_rd)
  );

  fir_agu #(.TAPS(TAPS)) u_agu (
    .clk      (clk),
    .rst      (rst),
    .start    (in_load),
    .step     (in_run),
    .base     (head),
    .coef_addr(agu_coef),
    .samp_addr(agu_samp)
  );

  fir_mac #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW)) u_mac (
    .clk    (clk),
    .rst    (rst),
    .clr    (in_load),
    .en     (in_run),
    .last   (last_step),
    .mx     ($signed(x_rd)),
    .my     ($signed(c_rd)),
    .y_valid(y_valid),
    .y_data (y_data)
  );
endmodule

// File: rtl/fir_mac_agu_chk.sv
module fir_mac_agu_chk #(
  parameter int TAPS = 8,
  parameter int OW   = 16,
  localparam int LW  = $clog2(TAPS + 3) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_ready,
  input logic          y_valid,
  input logic [OW-1:0] y_data
);
  logic [LW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  lat_cnt <= '0;
    else if (s_valid && s_ready) lat_cnt <= LW'(1);
    else if (y_valid)         lat_cnt <= '0;
    else if (lat_cnt != '0)   lat_cnt <= lat_cnt + 1'b1;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!y_valid && s_ready));

  assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  assert_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid);

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> (lat_cnt == LW'(TAPS + 2)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !y_valid |-> $stable(y_data));
endmodule

bind fir_mac_agu fir_mac_agu_chk #(.TAPS(TAPS), .OW(OW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .s_valid(s_valid),
  .s_ready(s_ready),
  .y_valid(y_valid),
  .y_data (y_data)
);

// File: tb/fir_mac_agu_bench.sv
`timescale 1ns/1ps
module fir_mac_agu_bench;
  localparam int TAPS = 4;
  localparam int DW   = 8;
  localparam int CW   = 8;
  localparam int OW   = 16;
  localparam int IW   = $clog2(TAPS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          coef_we = 1'b0;
  logic [IW-1:0] coef_addr = '0;
  logic [CW-1:0] coef_data = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          y_valid;
  logic [OW-1:0] y_data;

  int n_cmp = 0;
  int n_bad = 0;
  int coef_m [TAPS];
  int hist [$];

  always #4 clk = ~clk;

  fir_mac_agu #(.TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW)) u_fir_mac_agu (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .y_valid(y_valid), .y_data(y_data)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int model();
    longint s = 0;
    for (int i = 0; i < TAPS; i++) s += longint'(hist[hist.size()-1-i]) * coef_m[i];
    return clamp(s);
  endfunction

  task automatic wcoef(input int idx, input int val);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = IW'(idx); coef_data = CW'(val);
    @(negedge clk);
    coef_we = 1'b0;
    coef_m[idx] = val;
  endtask

  task automatic push(input int v, input bit chk, input string req);
    int exp;
    @(negedge clk);
    s_valid = 1'b1; s_data = DW'(v);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    hist.push_back(v);
    exp = model();
    for (int k = 0; k <= TAPS; k++) begin
      if (chk) begin
        check("R2 ready low while busy", s_ready, 0);
        check("R3 no early result", y_valid, 0);
      end
      @(negedge clk);
    end
    if (chk) begin
      check("R3 result pulse", y_valid, 1);
      check(req, longint'($signed(y_data)), exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 y_valid in reset", y_valid, 0);
    check("R1 s_ready in reset", s_ready, 1);
    check("R1 y_data in reset", y_data, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 y_valid after reset", y_valid, 0);
    check("R1 s_ready after reset", s_ready, 1);

    // R6: coefficient load
    wcoef(0, 3); wcoef(1, -5); wcoef(2, 7); wcoef(3, -2);
    for (int i = 0; i < TAPS; i++) push(0, 1'b0, "prime");

    // R4 / R5: impulse response reads back the coefficients and then dies out
    push(1, 1'b1, "R4 impulse tap0");
    for (int i = 0; i < TAPS + 2; i++) push(0, 1'b1, "R5 impulse tail");
    // R4: step input
    for (int i = 0; i < TAPS + 1; i++) push(1, 1'b1, "R4 step");
    // R5: scrambled sweep through all sample values wraps the ring many times
    for (int v = 0; v < 256; v++) push(((v * 37) % 256) - 128, 1'b1, "R5 sweep");

    // R6: reload coefficients mid-stream
    wcoef(0, 127); wcoef(1, -128); wcoef(2, 1); wcoef(3, 64);
    for (int v = 0; v < 40; v++) push(((v * 91 + 13) % 256) - 128, 1'b1, "R6 reloaded");

    // R7: positive clamp
    for (int i = 0; i < TAPS; i++) wcoef(i, -128);
    for (int i = 0; i < TAPS; i++) push(-128, 1'b1, "R7 positive clamp");
    check("R7 positive clamp value", longint'($signed(y_data)), 32767);
    // R7: negative clamp
    for (int i = 0; i < TAPS; i++) wcoef(i, 127);
    for (int i = 0; i < TAPS; i++) push(-128, 1'b1, "R7 negative clamp");
    check("R7 negative clamp value", longint'($signed(y_data)), -32768);

    // R8: partial sum leaves range and returns; exact result 256
    for (int i = 0; i < TAPS; i++) wcoef(i, -128);
    push(127, 1'b1, "R8 pre");
    push(127, 1'b1, "R8 pre");
    push(-128, 1'b1, "R8 pre");
    push(-128, 1'b1, "R8 final-only clamp");
    check("R8 exact value", longint'($signed(y_data)), 256);

    repeat (2) @(negedge clk);
    check("R3 output held", longint'($signed(y_data)), 256);
    summary();
    $finish;
  end
endmodule